// File: doc/BRIEF.md
# Endpoint Control Register Bank

This block holds one 16-bit control and status word per endpoint of a full-speed USB device controller. Software reaches the words over a simple single-cycle register bus. A transaction engine reads back each endpoint's word and signals every completed transfer. On that signal the block records the completion, advances the data toggle and parks the direction in NAK.

Each word combines three kinds of field. Plain read/write fields hold the endpoint address, type and kind. The two 2-bit status fields and the two data-toggle bits invert where a 1 is written. The two completion flags are cleared where a 0 is written. A single write can therefore acknowledge one event or re-arm one direction without disturbing the rest of the word, and software never needs a read-modify-write sequence.

Word layout, bit 15 down to bit 0: `rx_done` (15), `rx_tog` (14), `rx_stat` (13:12), reserved (11), `ep_type` (10:9), `ep_kind` (8), `tx_done` (7), `tx_tog` (6), `tx_stat` (5:4), `ep_addr` (3:0). Status codes are 00 disabled, 01 stall, 10 NAK and 11 valid. The kind bit requests double buffering on bulk endpoints and status-out handling on control endpoints. It is a stored bit only; this block does not act on it.

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: There are NUM_EP (default 8) words, selected by `addr_i` as the endpoint index. `rdata_o` returns the word at `addr_i` one clock after the address is presented.
- R2: A write inverts each bit of `rx_stat` (13:12) and `tx_stat` (5:4) where the write data holds 1, and leaves it unchanged where it holds 0.
- R3: A write inverts `rx_tog` (14) and `tx_tog` (6) where the write data holds 1, and leaves them unchanged where it holds 0.
- R4: A write clears `rx_done` (15) and `tx_done` (7) where the write data holds 0, and keeps them where it holds 1. Software can never set them.
- R5: `ep_type` (10:9), `ep_kind` (8) and `ep_addr` (3:0) take the written value directly. Bit 11 always reads 0, and writes to it are ignored.
- R6: A completion event (`xfer_vld_i`, endpoint `xfer_ep_i`, direction `xfer_in_i`, where 1 means transmit) on a direction whose status is 11 does three things: it sets that direction's done flag, inverts its toggle, and changes its status to 10.
- R7: A completion event on a direction whose status is not 11 changes nothing.
- R8: When a completion event and a software write to the same word fall in the same cycle, the done flag ends up set. Software toggle and status masks are then XORed onto the values the event produced.
- R9: Reset (`rst_ni` low) clears every word to 0x0000.
- R10: `eng_reg_o` shows the current word of endpoint `eng_ep_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Bus word index (endpoint) |
| we_i | input | 1 | Bus write strobe |
| wdata_i | input | 16 | Bus write data |
| rdata_o | output | 16 | Registered bus read data |
| xfer_vld_i | input | 1 | Transfer completed successfully |
| xfer_ep_i | input | 3 | Endpoint of the completed transfer |
| xfer_in_i | input | 1 | 1 = transmit direction, 0 = receive direction |
| eng_ep_i | input | 3 | Endpoint the engine reads back |
| eng_reg_o | output | 16 | Word of endpoint `eng_ep_i` |

## Verification
A walked vector table writes masks to several endpoints. The masks are chosen so that the three write rules give visibly different results from a plain store: all-zero writes, writes of 1 to clear-on-zero flags, the same toggle mask applied twice, and writes to the reserved bit. Directed sequences then drive completion events in both directions. Each event lands either on an armed direction or on a NAK direction, which separates the update path from the ignore path. One event coincides with a software clear of the same flag, which shows whether the hardware set wins. The engine read-back port is compared against the bus view of the same word.

// File: rtl/usb_ep_ctrl_pkg.sv
package usb_ep_ctrl_pkg;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } ep_stat_e;

  // bit positions are part of the software contract
  typedef struct packed {
    logic              rx_done;  // 15
    logic              rx_tog;   // 14
    logic [1:0]        rx_stat;  // 13:12
    logic              rsv;      // 11
    logic [1:0]        ep_type;  // 10:9
    logic              ep_kind;  // 8
    logic              tx_done;  // 7
    logic              tx_tog;   // 6
    logic [1:0]        tx_stat;  // 5:4
    logic [ADDR_W-1:0] ep_addr;  // 3:0
  } ep_reg_t;

endpackage

// File: rtl/ep_dir_ctl.sv
module ep_dir_ctl
  import usb_ep_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_we_i,
  input  logic       sw_done_i,
  input  logic       sw_tog_i,
  input  logic [1:0] sw_stat_i,
  input  logic       hw_evt_i,
  output logic       done_o,
  output logic       tog_o,
  output logic [1:0] stat_o
);

  logic       done_q, done_d;
  logic       tog_q, tog_d;
  logic [1:0] stat_q, stat_d;
  logic       hw_fire;

  assign hw_fire = hw_evt_i && (stat_q == ST_VALID);

  always_comb begin
    done_d = done_q;
    tog_d  = tog_q;
    stat_d = stat_q;
    if (hw_fire) begin
      tog_d  = ~tog_q;
      stat_d = ST_NAK;
    end
    if (sw_we_i) begin
      done_d = done_q & sw_done_i;
      tog_d  = tog_d ^ sw_tog_i;
      stat_d = stat_d ^ sw_stat_i;
    end
    // event set wins over a same-cycle clear
    if (hw_fire) done_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      tog_q  <= 1'b0;
      stat_q <= ST_DIS;
    end else begin
      done_q <= done_d;
      tog_q  <= tog_d;
      stat_q <= stat_d;
    end
  end

  assign done_o = done_q;
  assign tog_o  = tog_q;
  assign stat_o = stat_q;

  assert_evt_sets_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_fire |=> done_q);

  assert_evt_parks_nak_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_fire && !(sw_we_i && (sw_stat_i != 2'b00))) |=> (stat_q == ST_NAK));

  assert_done_only_by_hw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_fire |=> !$rose(done_q));

  assert_tog_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(sw_we_i && sw_tog_i) && !hw_fire) |=> $stable(tog_q));

  assert_evt_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_evt_i && (stat_q != ST_VALID) && !sw_we_i) |=>
      ($stable(stat_q) && $stable(done_q) && $stable(tog_q)));

endmodule

// File: rtl/ep_slot.sv
module ep_slot
  import usb_ep_ctrl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sw_we_i,
  input  ep_reg_t sw_wdata_i,
  input  logic    hw_evt_rx_i,
  input  logic    hw_evt_tx_i,
  output ep_reg_t reg_o
);

  logic [1:0]        type_q;
  logic              kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              unused_rsv;

  assign unused_rsv = sw_wdata_i.rsv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      kind_q <= 1'b0;
      addr_q <= '0;
    end else if (sw_we_i) begin
      type_q <= sw_wdata_i.ep_type;
      kind_q <= sw_wdata_i.ep_kind;
      addr_q <= sw_wdata_i.ep_addr;
    end
  end

  ep_dir_ctl i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (sw_we_i),
    .sw_done_i (sw_wdata_i.rx_done),
    .sw_tog_i  (sw_wdata_i.rx_tog),
    .sw_stat_i (sw_wdata_i.rx_stat),
    .hw_evt_i  (hw_evt_rx_i),
    .done_o    (reg_o.rx_done),
    .tog_o     (reg_o.rx_tog),
    .stat_o    (reg_o.rx_stat)
  );

  ep_dir_ctl i_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (sw_we_i),
    .sw_done_i (sw_wdata_i.tx_done),
    .sw_tog_i  (sw_wdata_i.tx_tog),
    .sw_stat_i (sw_wdata_i.tx_stat),
    .hw_evt_i  (hw_evt_tx_i),
    .done_o    (reg_o.tx_done),
    .tog_o     (reg_o.tx_tog),
    .stat_o    (reg_o.tx_stat)
  );

  assign reg_o.rsv     = 1'b0;
  assign reg_o.ep_type = type_q;
  assign reg_o.ep_kind = kind_q;
  assign reg_o.ep_addr = addr_q;

  assert_rw_fields_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (reg_o.ep_addr == $past(sw_wdata_i.ep_addr)) &&
                (reg_o.ep_type == $past(sw_wdata_i.ep_type)));

endmodule

// File: rtl/ep_rd_mux.sv
module ep_rd_mux
  import usb_ep_ctrl_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned SEL_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic [NUM_EP-1:0][REG_W-1:0] regs_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [REG_W-1:0]             data_o
);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel_i == SEL_W'(i)) data_o = regs_i[i];
    end
  end

endmodule

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
  import usb_ep_ctrl_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EP_W-1:0]  addr_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             xfer_vld_i,
  input  logic [EP_W-1:0]  xfer_ep_i,
  input  logic             xfer_in_i,
  input  logic [EP_W-1:0]  eng_ep_i,
  output logic [REG_W-1:0] eng_reg_o
);

  logic [NUM_EP-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]             bus_sel;
  logic [REG_W-1:0]             rdata_q;
  ep_reg_t                      wdata_s;

  assign wdata_s = ep_reg_t'(wdata_i);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic    hit_wr, hit_evt;
    ep_reg_t slot_q;

    assign hit_wr  = we_i && (addr_i == EP_W'(g));
    assign hit_evt = xfer_vld_i && (xfer_ep_i == EP_W'(g));

    ep_slot i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sw_we_i     (hit_wr),
      .sw_wdata_i  (wdata_s),
      .hw_evt_rx_i (hit_evt && !xfer_in_i),
      .hw_evt_tx_i (hit_evt && xfer_in_i),
      .reg_o       (slot_q)
    );

    assign regs[g] = slot_q;
  end

  ep_rd_mux #(.NUM_EP(NUM_EP)) i_bus_mux (
    .regs_i (regs),
    .sel_i  (addr_i),
    .data_o (bus_sel)
  );

  ep_rd_mux #(.NUM_EP(NUM_EP)) i_eng_mux (
    .regs_i (regs),
    .sel_i  (eng_ep_i),
    .data_o (eng_reg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= bus_sel;
  end

  assign rdata_o = rdata_q;

  assert_rsv_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_reg_o[11] == 1'b0) && (rdata_o[11] == 1'b0));

  assert_rd_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !xfer_vld_i && (eng_ep_i == addr_i)) |=> (rdata_o == $past(eng_reg_o)));

endmodule

// File: tb/test_usb_ep_ctrl_bank.sv
module test_usb_ep_ctrl_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  localparam logic [2:0]  V_EP [NV] = '{3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd7, 3'd1};
  localparam logic [15:0] V_WD [NV] = '{16'h0000, 16'h0735, 16'h3025, 16'h4840,
                                        16'h4840, 16'h808F, 16'h3025};
  localparam logic [15:0] V_EX [NV] = '{16'h0000, 16'h0735, 16'h3015, 16'h4040,
                                        16'h0000, 16'h000F, 16'h0035};
  localparam string V_RQ [NV] = '{"R4", "R2", "R5", "R3", "R3", "R4", "R2"};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        xfer_vld = 1'b0;
  logic [2:0]  xfer_ep = '0;
  logic        xfer_in = 1'b0;
  logic [2:0]  eng_ep = '0;
  logic [15:0] eng_reg;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_ctrl_bank i_usb_ep_ctrl_bank (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .we_i       (we),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .xfer_vld_i (xfer_vld),
    .xfer_ep_i  (xfer_ep),
    .xfer_in_i  (xfer_in),
    .eng_ep_i   (eng_ep),
    .eng_reg_o  (eng_reg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] ep, input logic [15:0] d);
    addr = ep; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] ep, output logic [15:0] d);
    addr = ep;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic evt(input logic [2:0] ep, input logic dir_in);
    xfer_ep = ep; xfer_in = dir_in; xfer_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: every word zero after reset
    for (int i = 0; i < 8; i++) begin
      bus_rd(3'(i), r);
      check("R9", r, 16'h0000);
    end

    // vector table, R1 read-after-write path
    for (int i = 0; i < NV; i++) begin
      bus_wr(V_EP[i], V_WD[i]);
      bus_rd(V_EP[i], r);
      check(V_RQ[i], r, V_EX[i]);
    end

    // R6 transmit completion on armed endpoint
    bus_wr(3'd3, 16'h0030);
    evt(3'd3, 1'b1);
    bus_rd(3'd3, r);
    check("R6", r, 16'h00E0);
    // R4 writing 1 keeps done, writing 0 clears it
    bus_wr(3'd3, 16'h0080);
    bus_rd(3'd3, r);
    check("R4", r, 16'h00E0);
    bus_wr(3'd3, 16'h0000);
    bus_rd(3'd3, r);
    check("R4", r, 16'h0060);

    // R6 receive completion
    bus_wr(3'd4, 16'h3000);
    evt(3'd4, 1'b0);
    bus_rd(3'd4, r);
    check("R6", r, 16'hE000);
    // R7 event on NAK receive and disabled transmit
    evt(3'd4, 1'b0);
    evt(3'd4, 1'b1);
    bus_rd(3'd4, r);
    check("R7", r, 16'hE000);

    // R8 event and clear in the same cycle
    bus_wr(3'd4, 16'h9000);
    bus_rd(3'd4, r);
    check("R2", r, 16'hF000);
    addr = 3'd4; wdata = 16'h0000; we = 1'b1;
    xfer_ep = 3'd4; xfer_in = 1'b0; xfer_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; xfer_vld = 1'b0;
    bus_rd(3'd4, r);
    check("R8", r, 16'hA000);
    bus_wr(3'd4, 16'h0000);
    bus_rd(3'd4, r);
    check("R4", r, 16'h2000);

    // R10 engine view
    eng_ep = 3'd4;
    #1;
    check("R10", eng_reg, 16'h2000);
    eng_ep = 3'd1;
    #1;
    check("R10", eng_reg, 16'h0035);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule